// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block produces the pixel and line counters, the horizontal and vertical sync strobes, a composite sync and a data-enable for a raster display. Both counters start at the top-left pixel of the active picture, so position zero is the first visible pixel and not a sync edge. The block runs either progressive or interlaced. In interlaced mode it alternates between two fields. The odd field is one line longer. Its vertical sync starts one line later and ends one line later, and both of its edges sit half a line ahead of the horizontal sync start pixel. Because of this, the lines left after vertical sync are the same count in both fields.

Software programs the timing through a small write-only configuration port. Timing values go into shadow registers, and those are copied into the live set when the counters return to the origin. A change therefore never tears a field in the middle. Control settings (output enable, sync polarity, interface mode, blank colour) act on the next clock. While output is disabled in 24-bit RGB mode, the pixel data output carries the blank colour. In any other interface mode, the pixel data passes through untouched.

Top module: `vtg_top`

## Requirements
- R1: `hcount` runs from 0 to h_total-1 and advances only on clocks with `pix_en` high. `vcount` advances when `hcount` wraps. Both are 0 after reset and hold while `pix_en` is low.
- R2: While enabled, `de` is high exactly when `hcount` < h_active (address 0) and `vcount` < v_active (address 4).
- R3: The raw horizontal sync is high for h_sync_start (address 1) <= `hcount` < h_sync_end (address 2). The line length is h_total (address 3).
- R4: An even or progressive field is v_total lines long (address 7). Its raw vertical sync rises at (line v_sync_start, pixel h_sync_start) and falls at (line v_sync_end, pixel h_sync_start), from addresses 5 and 6.
- R5: An odd field is v_total+1 lines long. Its raw vertical sync rises at (line v_sync_start+1, pixel h_sync_start - h_total/2) and falls at (line v_sync_end+1, the same pixel). The lines after sync therefore match the even field.
- R6: At each wrap to the origin, `field_odd` becomes the inverse of its value if the interlace bit being loaded (address 8 bit 0) is 1. Otherwise it becomes 0. It changes at no other time.
- R7: `frame_start` is high for one clock right after the counters wrap to (0,0), and only then.
- R8: Writes to addresses 0 to 8 change nothing until the next wrap to the origin, which loads them all at once.
- R9: Address 9 bits 2, 3 and 4 invert `hsync`, `vsync` and `csync` to active low. The raw composite sync is raw hsync XOR raw vsync.
- R10: Address 9 bit 0 is the output enable. While it is 0, `de` is 0 and every sync sits at its inactive level.
- R11: When the enable is 0 and address 9 bit 1 (24-bit RGB mode) is 1, `pix_out` equals the blank colour (address 10). In every other case `pix_out` equals `pix_in`.
- R12: Writes to addresses 9 and 10 act from the clock after the write.
- R13: Writes to addresses 11 to 15 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel advance enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration register address |
| cfg_wdata | input | CW | Configuration write data |
| pix_in | input | CW | Incoming pixel data |
| hcount | output | HW | Pixel position in line |
| vcount | output | VW | Line position in field |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| csync | output | 1 | Composite sync after polarity |
| de | output | 1 | Active-area data enable |
| frame_start | output | 1 | One-clock pulse at the field origin |
| field_odd | output | 1 | Current field is odd |
| pix_out | output | CW | Pixel data or blank colour |

## Verification
The generator is first run progressive, which gives the plain vertical sync placement. Interlace is then switched on in the middle of a field, to show that the shadow copy delays the change, and to let odd and even fields alternate so that the extra line and the half-line sync offset can be told apart. A gappy `pix_en` pattern separates counting on advance from counting every clock. A mid-field change of line length shows that the odd-field sync pixel tracks h_total/2. Polarity, disable with and without 24-bit mode, and writes to unused addresses test the output stage separately from the counters.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int unsigned A_HACT  = 0;
  localparam int unsigned A_HSS   = 1;
  localparam int unsigned A_HSE   = 2;
  localparam int unsigned A_HTOT  = 3;
  localparam int unsigned A_VACT  = 4;
  localparam int unsigned A_VSS   = 5;
  localparam int unsigned A_VSE   = 6;
  localparam int unsigned A_VTOT  = 7;
  localparam int unsigned A_MODE  = 8;
  localparam int unsigned A_CTRL  = 9;
  localparam int unsigned A_BLANK = 10;

  localparam int unsigned C_EN    = 0;
  localparam int unsigned C_RGB24 = 1;
  localparam int unsigned C_INVH  = 2;
  localparam int unsigned C_INVV  = 3;
  localparam int unsigned C_INVC  = 4;
  localparam int unsigned CTRL_W  = 5;

  // pixel at which vertical sync edges fall in a field
  function automatic logic [31:0] vs_pixel(logic [31:0] hss, logic [31:0] htot, logic odd);
    return odd ? (hss - (htot >> 1)) : hss;
  endfunction

  // raster position (l,p) is at or after position (lr,pr)
  function automatic logic at_or_after(logic [31:0] l, logic [31:0] p,
                                       logic [31:0] lr, logic [31:0] pr);
    return (l > lr) || ((l == lr) && (p >= pr));
  endfunction
endpackage

// File: rtl/vtg_shadow_reg.sv
module vtg_shadow_reg #(
  parameter int W    = 12,
  parameter int AW   = 4,
  parameter int ADDR = 0,
  parameter logic [W-1:0] RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          load,
  output logic [W-1:0]  shadow,
  output logic [W-1:0]  live
);
  localparam logic [AW-1:0] MY_ADDR = AW'(ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= RST;
      live   <= RST;
    end else begin
      if (load) live <= shadow;
      if (we && addr == MY_ADDR) shadow <= wdata;
    end
  end
endmodule

// File: rtl/vtg_cfg.sv
module vtg_cfg #(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int CW = 24,
  parameter int AW = 4,
  parameter int H_ACT_RST = 8,
  parameter int H_SS_RST  = 10,
  parameter int H_SE_RST  = 12,
  parameter int H_TOT_RST = 16,
  parameter int V_ACT_RST = 4,
  parameter int V_SS_RST  = 5,
  parameter int V_SE_RST  = 7,
  parameter int V_TOT_RST = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          load,
  output logic [HW-1:0] h_act,
  output logic [HW-1:0] h_ss,
  output logic [HW-1:0] h_se,
  output logic [HW-1:0] h_tot,
  output logic [VW-1:0] v_act,
  output logic [VW-1:0] v_ss,
  output logic [VW-1:0] v_se,
  output logic [VW-1:0] v_tot,
  output logic          ilace_live,
  output logic          ilace_next,
  output logic [vtg_pkg::CTRL_W-1:0] ctrl,
  output logic [CW-1:0] blank
);
  import vtg_pkg::*;

  // horizontal live/shadow pairs; shadow sides are not needed outside
  logic [HW-1:0] h_sh [4];
  logic [VW-1:0] v_sh [4];
  logic [HW-1:0] h_lv [4];
  logic [VW-1:0] v_lv [4];
  localparam int H_RST [4] = '{H_ACT_RST, H_SS_RST, H_SE_RST, H_TOT_RST};
  localparam int V_RST [4] = '{V_ACT_RST, V_SS_RST, V_SE_RST, V_TOT_RST};

  for (genvar i = 0; i < 4; i++) begin : g_timing
    vtg_shadow_reg #(.W(HW), .AW(AW), .ADDR(int'(A_HACT) + i), .RST(HW'(H_RST[i]))) u_h (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata[HW-1:0]), .load(load), .shadow(h_sh[i]), .live(h_lv[i]));
    vtg_shadow_reg #(.W(VW), .AW(AW), .ADDR(int'(A_VACT) + i), .RST(VW'(V_RST[i]))) u_v (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata[VW-1:0]), .load(load), .shadow(v_sh[i]), .live(v_lv[i]));
  end

  vtg_shadow_reg #(.W(1), .AW(AW), .ADDR(A_MODE), .RST(1'b0)) u_mode (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata[0:0]), .load(load), .shadow(ilace_next), .live(ilace_live));

  assign h_act = h_lv[0];
  assign h_ss  = h_lv[1];
  assign h_se  = h_lv[2];
  assign h_tot = h_lv[3];
  assign v_act = v_lv[0];
  assign v_ss  = v_lv[1];
  assign v_se  = v_lv[2];
  assign v_tot = v_lv[3];

  // control and blank colour act immediately (no shadow)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= CTRL_W'(1 << C_RGB24);
      blank <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == AW'(A_CTRL))  ctrl  <= cfg_wdata[CTRL_W-1:0];
      if (cfg_addr == AW'(A_BLANK)) blank <= cfg_wdata;
    end
  end
endmodule

// File: rtl/vtg_counter.sv
module vtg_counter #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic [HW-1:0] h_tot,
  input  logic [VW-1:0] v_tot,
  input  logic          next_ilace,
  output logic [HW-1:0] hcount,
  output logic [VW-1:0] vcount,
  output logic          field,
  output logic          wrap,
  output logic          fs_pulse
);
  logic [VW:0] v_tot_eff;
  logic        h_last, v_last;

  // odd field carries one extra line
  assign v_tot_eff = {1'b0, v_tot} + (VW+1)'(field);
  assign h_last    = ({1'b0, hcount} + (HW+1)'(1)) >= {1'b0, h_tot};
  assign v_last    = ({1'b0, vcount} + (VW+1)'(1)) >= v_tot_eff;
  assign wrap      = pix_en & h_last & v_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcount   <= '0;
      vcount   <= '0;
      field    <= 1'b0;
      fs_pulse <= 1'b0;
    end else begin
      fs_pulse <= wrap;
      if (pix_en) begin
        if (h_last) begin
          hcount <= '0;
          if (v_last) begin
            vcount <= '0;
            field  <= next_ilace & ~field;
          end else begin
            vcount <= vcount + VW'(1);
          end
        end else begin
          hcount <= hcount + HW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vtg_decode.sv
module vtg_decode #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic [HW-1:0] hcount,
  input  logic [VW-1:0] vcount,
  input  logic          field,
  input  logic [HW-1:0] h_act,
  input  logic [HW-1:0] h_ss,
  input  logic [HW-1:0] h_se,
  input  logic [HW-1:0] h_tot,
  input  logic [VW-1:0] v_act,
  input  logic [VW-1:0] v_ss,
  input  logic [VW-1:0] v_se,
  output logic          hs_raw,
  output logic          vs_raw,
  output logic          de_raw
);
  import vtg_pkg::*;

  logic [31:0] vpix, vsl, vel, hc, vc;

  assign hc   = 32'(hcount);
  assign vc   = 32'(vcount);
  assign vpix = vs_pixel(32'(h_ss), 32'(h_tot), field);
  assign vsl  = 32'(v_ss) + 32'(field);
  assign vel  = 32'(v_se) + 32'(field);

  assign hs_raw = (hcount >= h_ss) && (hcount < h_se);
  assign vs_raw = at_or_after(vc, hc, vsl, vpix) && !at_or_after(vc, hc, vel, vpix);
  assign de_raw = (hcount < h_act) && (vcount < v_act);
endmodule

// File: rtl/vtg_top.sv
module vtg_top #(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int CW = 24,
  parameter int AW = 4,
  parameter int H_ACT_RST = 8,
  parameter int H_SS_RST  = 10,
  parameter int H_SE_RST  = 12,
  parameter int H_TOT_RST = 16,
  parameter int V_ACT_RST = 4,
  parameter int V_SS_RST  = 5,
  parameter int V_SE_RST  = 7,
  parameter int V_TOT_RST = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic [CW-1:0] pix_in,
  output logic [HW-1:0] hcount,
  output logic [VW-1:0] vcount,
  output logic          hsync,
  output logic          vsync,
  output logic          csync,
  output logic          de,
  output logic          frame_start,
  output logic          field_odd,
  output logic [CW-1:0] pix_out
);
  import vtg_pkg::*;

  logic [HW-1:0] h_act_q, h_ss_q, h_se_q, h_tot_q;
  logic [VW-1:0] v_act_q, v_ss_q, v_se_q, v_tot_q;
  logic          ilace_q, ilace_nxt, wrap;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CW-1:0] blank_q;
  logic          hs_raw, vs_raw, de_raw;
  logic          en_q, rgb_q;

  vtg_cfg #(
    .HW(HW), .VW(VW), .CW(CW), .AW(AW),
    .H_ACT_RST(H_ACT_RST), .H_SS_RST(H_SS_RST), .H_SE_RST(H_SE_RST), .H_TOT_RST(H_TOT_RST),
    .V_ACT_RST(V_ACT_RST), .V_SS_RST(V_SS_RST), .V_SE_RST(V_SE_RST), .V_TOT_RST(V_TOT_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .load(wrap),
    .h_act(h_act_q), .h_ss(h_ss_q), .h_se(h_se_q), .h_tot(h_tot_q),
    .v_act(v_act_q), .v_ss(v_ss_q), .v_se(v_se_q), .v_tot(v_tot_q),
    .ilace_live(ilace_q), .ilace_next(ilace_nxt), .ctrl(ctrl_q), .blank(blank_q));

  vtg_counter #(.HW(HW), .VW(VW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .h_tot(h_tot_q), .v_tot(v_tot_q),
    .next_ilace(ilace_nxt), .hcount(hcount), .vcount(vcount), .field(field_odd),
    .wrap(wrap), .fs_pulse(frame_start));

  vtg_decode #(.HW(HW), .VW(VW)) u_dec (
    .hcount(hcount), .vcount(vcount), .field(field_odd),
    .h_act(h_act_q), .h_ss(h_ss_q), .h_se(h_se_q), .h_tot(h_tot_q),
    .v_act(v_act_q), .v_ss(v_ss_q), .v_se(v_se_q),
    .hs_raw(hs_raw), .vs_raw(vs_raw), .de_raw(de_raw));

  assign en_q  = ctrl_q[C_EN];
  assign rgb_q = ctrl_q[C_RGB24];

  assign de      = de_raw & en_q;
  assign hsync   = (hs_raw & en_q) ^ ctrl_q[C_INVH];
  assign vsync   = (vs_raw & en_q) ^ ctrl_q[C_INVV];
  assign csync   = ((hs_raw ^ vs_raw) & en_q) ^ ctrl_q[C_INVC];
  assign pix_out = (!en_q && rgb_q) ? blank_q : pix_in;
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic [HW-1:0] hcount,
  input logic [VW-1:0] vcount,
  input logic [HW-1:0] h_tot_q,
  input logic          frame_start,
  input logic          field_odd,
  input logic          ilace_q,
  input logic          en_q,
  input logic          rgb_q,
  input logic          de,
  input logic [CW-1:0] blank_q,
  input logic [CW-1:0] pix_out
);
  // R1: counters hold while pixel advance is low
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(hcount) && $stable(vcount)));

  // R1: horizontal counter stays below the live line length
  p_hrange_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hcount < h_tot_q);

  // R7: frame start pulse only at the origin
  p_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (hcount == '0 && vcount == '0));

  // R6: field flag changes only together with a frame start
  p_field_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |-> $stable(field_odd));

  // R6: progressive operation stays in the even field
  p_prog_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ilace_q |-> !field_odd);

  // R10: data enable gated by output enable
  p_de_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !de);

  // R11: blank colour while disabled in 24-bit mode
  p_blank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && rgb_q) |-> (pix_out == blank_q));
endmodule

bind vtg_top vtg_checker #(.HW(HW), .VW(VW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hcount(hcount), .vcount(vcount),
  .h_tot_q(h_tot_q), .frame_start(frame_start), .field_odd(field_odd),
  .ilace_q(ilace_q), .en_q(en_q), .rgb_q(rgb_q), .de(de),
  .blank_q(blank_q), .pix_out(pix_out));

// File: tb/tb_vtg_top.sv
`timescale 1ns/1ps
module tb_vtg_top;
  localparam int HW = 12, VW = 11, CW = 24, AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_en = 1'b1;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [CW-1:0] pix_in = '0;
  logic [HW-1:0] hcount;
  logic [VW-1:0] vcount;
  logic hsync, vsync, csync, de, frame_start, field_odd;
  logic [CW-1:0] pix_out;

  vtg_top dut (.*);

  always #2.5 clk = ~clk;

  // ---------------- reference model ----------------
  int sh [0:8];
  int lv [0:8];
  int m_h, m_v, m_f, m_fs, m_ctrl, m_blank;
  int pe_mode = 0;
  int n_vec = 0, n_bad = 0;
  bit cmp_on = 0;
  string phase = "init";

  function automatic void model_reset();
    int d [0:8] = '{8, 10, 12, 16, 4, 5, 7, 9, 0};
    for (int i = 0; i < 9; i++) begin sh[i] = d[i]; lv[i] = d[i]; end
    m_h = 0; m_v = 0; m_f = 0; m_fs = 0; m_ctrl = 2; m_blank = 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit wr;
      wr = 0;
      if (pix_en) begin
        if (m_h >= lv[3] - 1) begin
          m_h = 0;
          if (m_v >= lv[7] + m_f - 1) begin m_v = 0; wr = 1; end
          else m_v++;
        end else m_h++;
      end
      m_fs = wr;
      if (wr) begin
        m_f = (sh[8] != 0) ? 1 - m_f : 0;
        for (int i = 0; i < 9; i++) lv[i] = sh[i];
      end
      if (cfg_we) begin
        if (cfg_addr <= 7) sh[cfg_addr] = int'(cfg_wdata);
        else if (cfg_addr == 8) sh[8] = int'(cfg_wdata[0]);
        else if (cfg_addr == 9) m_ctrl = int'(cfg_wdata[4:0]);
        else if (cfg_addr == 10) m_blank = int'(cfg_wdata);
      end
    end
  end

  // ---------------- stimulus drivers ----------------
  int pe_cnt = 0;
  always @(posedge clk) begin
    #1;
    pix_in <= pix_in + 24'h010203;
    pe_cnt++;
    case (pe_mode)
      1: pix_en <= pe_cnt[0];
      2: pix_en <= ($urandom % 3) != 0;
      default: pix_en <= 1'b1;
    endcase
  end

  task automatic chk(string req, string nm, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s at t=%0t: actual %0d expected %0d", req, phase, nm, $time, act, exp);
    end
  endtask

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      int hs, vs, en, vp, pos, st, en_pos, e_de, e_pix;
      hs  = (m_h >= lv[1] && m_h < lv[2]) ? 1 : 0;
      vp  = m_f ? lv[1] - lv[3] / 2 : lv[1];
      pos = m_v * lv[3] + m_h;
      st     = (lv[5] + m_f) * lv[3] + vp;
      en_pos = (lv[6] + m_f) * lv[3] + vp;
      vs  = (pos >= st && pos < en_pos) ? 1 : 0;
      en  = m_ctrl & 1;
      e_de = (en && m_h < lv[0] && m_v < lv[4]) ? 1 : 0;
      e_pix = (!en && ((m_ctrl >> 1) & 1)) ? m_blank : int'(pix_in);
      chk("R1", "hcount", int'(hcount), m_h);
      chk("R1", "vcount", int'(vcount), m_v);
      chk(en ? "R2" : "R10", "de", int'(de), e_de);
      chk("R3/R9", "hsync", int'(hsync), (hs & en) ^ ((m_ctrl >> 2) & 1));
      chk(m_f ? "R5" : "R4", "vsync", int'(vsync), (vs & en) ^ ((m_ctrl >> 3) & 1));
      chk("R9", "csync", int'(csync), ((hs ^ vs) & en) ^ ((m_ctrl >> 4) & 1));
      chk("R7", "frame_start", int'(frame_start), m_fs);
      chk("R6", "field_odd", int'(field_odd), m_f);
      chk("R11", "pix_out", int'(pix_out), e_pix);
    end
  end

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = CW'(d);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic run_tests();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state (R1, R6, R7)
    chk("R1", "reset hcount", int'(hcount), 0);
    chk("R6", "reset field", int'(field_odd), 0);
    chk("R7", "reset frame_start", int'(frame_start), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    cmp_on = 1;
    phase = "disabled rgb24 R11";
    run(60);
    phase = "enable R12";
    wr(9, 5'b00011);
    run(300);
    phase = "interlace mid-field R8 R6";
    run(37);
    wr(8, 1);
    run(700);
    phase = "polarity R9";
    wr(9, 5'b11101);
    run(320);
    phase = "gappy pix_en R1";
    pe_mode = 1;
    run(700);
    pe_mode = 2;
    run(600);
    pe_mode = 0;
    phase = "line length change R8 R5";
    wr(3, 20); wr(1, 12); wr(2, 14);
    run(900);
    phase = "unused address R13";
    wr(13, 24'hFFFFFF);
    wr(11, 0);
    run(200);
    phase = "blank colour R12 R11";
    wr(10, 24'hA5C3E1);
    wr(9, 5'b00010);
    run(100);
    phase = "disabled passthrough R11";
    wr(9, 5'b00000);
    run(100);
    phase = "progressive again R6";
    wr(9, 5'b00011);
    wr(8, 0);
    run(700);
  endtask

  initial begin
    bit timeout;
    timeout = 0;
    fork
      run_tests();
      begin run(150000); timeout = 1; end
    join_any
    disable fork;
    if (timeout) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule